// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product into a 64-bit accumulator held as two 32-bit halves: a high word and a low word. It has two operand widths. Long mode multiplies full 32-bit operands. Word mode multiplies the low 16 bits of each operand. A per-operation saturate input picks between wrapping arithmetic and clamping arithmetic. The clamp width depends on the mode. Long mode clamps to a signed 48-bit range. Word mode clamps the low word to a signed 32-bit range and marks the clamp by writing 1 into the high word.

Operands arrive with a one-cycle valid strobe. The product is registered in the first cycle. The accumulator is rewritten in the second cycle, and a done pulse is raised in that same cycle. Issuing operations back to back is allowed, because each operation reads the accumulator value left by the one before it. For testing, a clear input zeroes the accumulator, and two load strobes write either half from a shared data bus.

Top module: `mac_sat_unit`

## Requirements
- R1: While reset is low and after it is released, both accumulator halves read 0 and done is 0.
- R2: An operation whose valid is sampled at clock edge k updates the accumulator at edge k+1. Done is 1 for exactly the cycle after edge k+1. Operations issued on consecutive cycles each see the result of the previous one.
- R3: In long mode (mode=1) with saturate off, the 64-bit signed product of the operands is added to {high,low} with 64-bit wraparound.
- R4: In word mode (mode=0), only bits 15:0 of each operand are used, taken as signed. Bits 31:16 have no effect. With saturate off, the sign-extended product is added to {high,low} with 64-bit wraparound.
- R5: In long mode with saturate on, a signed overflow of the 64-bit add gives 0x00007FFF_FFFFFFFF if the old accumulator was non-negative and 0xFFFF8000_00000000 if it was negative.
- R6: In long mode with saturate on and no 64-bit overflow, the sum is clamped to the signed 48-bit range, to those same two bounds.
- R7: The high half always receives bits 63:32 of the 64-bit result and the low half receives bits 31:0.
- R8: In word mode with saturate on, the sign-extended low half plus the product is clamped to the signed 32-bit range. If clamping changes the value, the low half takes the bound (0x7FFFFFFF or 0x80000000) and the high half becomes 1.
- R9: In word mode with saturate on and no clamp, the low half takes the sum and the high half keeps its old value.
- R10: Clear zeroes both halves at the next edge. It takes priority over loads and over an accumulate in the same cycle.
- R11: Load-high and load-low each write the data bus into their half at the next edge. A load suppresses any accumulate in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operands present this cycle |
| op_long | input | 1 | 1 = 32x32 long mode, 0 = 16x16 word mode |
| op_sat | input | 1 | 1 = saturating accumulate |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| acc_clr | input | 1 | Zero the accumulator |
| ld_hi | input | 1 | Load the high half from ld_data |
| ld_lo | input | 1 | Load the low half from ld_data |
| ld_data | input | 32 | Load data |
| done | output | 1 | Accumulator updated by an operation |
| acc_hi | output | 32 | Accumulator high half |
| acc_lo | output | 32 | Accumulator low half |

## Verification
Random operands are applied in all four mode and saturate combinations. Each random operation starts from a freshly loaded accumulator that is often placed near the 48-bit, 32-bit or 64-bit limits, so the clamp paths are hit in both directions. Word-mode operands carry random upper bits; any dependence on them shows up as a mismatch. Directed cases separate three long-mode outcomes: a true 64-bit overflow, which takes the bound chosen by the old accumulator's sign; a 48-bit clamp without overflow; and a plain wrap when saturate is off. They also separate a word-mode clamp, which sets the high word to 1, from a word-mode in-range sum, which leaves the high word untouched. A back-to-back pair tests the dependency between consecutive operations.

// File: rtl/mac_sat_pkg.sv
// Shared types for the saturating multiply-accumulate unit.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package mac_sat_pkg;

    typedef enum logic {
        MODE_WORD = 1'b0,
        MODE_LONG = 1'b1
    } mac_mode_e;

    // control that travels with a product through the first stage
    typedef struct packed {
        logic      vld;
        mac_mode_e mode;
        logic      sat;
    } mac_ctl_t;

endpackage

// File: rtl/mac_sat_mult.sv
// Stage one: forms the signed product and registers it with its control.
// Word mode uses the low half of each operand; long mode uses all DW bits.
// Assumes: DW is even; synchronous active-low reset.
module mac_sat_mult
    import mac_sat_pkg::*;
#(
    parameter int DW = 32,
    localparam int HW = DW / 2,
    localparam int PW = 2 * DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic                 in_long,
    input  logic                 in_sat,
    input  logic [DW-1:0]        in_a,
    input  logic [DW-1:0]        in_b,
    output mac_ctl_t             s1_ctl,
    output logic signed [PW-1:0] s1_prod
);

    logic signed [DW-1:0] a_l, b_l;
    logic signed [HW-1:0] a_w, b_w;
    logic signed [PW-1:0] prod_long, prod_word, prod_sel;

    // pick the product that the requested mode calls for
    always_comb begin
        a_l       = in_a;
        b_l       = in_b;
        a_w       = in_a[HW-1:0];
        b_w       = in_b[HW-1:0];
        prod_long = a_l * b_l;
        prod_word = a_w * b_w;
        prod_sel  = in_long ? prod_long : prod_word;
    end

    // stage register for control and product
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_ctl  <= '{vld: 1'b0, mode: MODE_WORD, sat: 1'b0};
            s1_prod <= '0;
        end else begin
            s1_ctl.vld <= in_vld;
            if (in_vld) begin
                s1_ctl.mode <= in_long ? MODE_LONG : MODE_WORD;
                s1_ctl.sat  <= in_sat;
                s1_prod     <= prod_sel;
            end
        end
    end

endmodule

// File: rtl/mac_sat_next.sv
// Combinational next-value logic: adds the registered product into the
// accumulator and applies the mode-dependent saturation.
// Assumes: LSAT_W lies strictly between DW and 2*DW.
module mac_sat_next
    import mac_sat_pkg::*;
#(
    parameter int DW     = 32,
    parameter int LSAT_W = 48,
    localparam int AW    = 2 * DW
) (
    input  mac_mode_e            mode,
    input  logic                 sat,
    input  logic signed [AW-1:0] prod,
    input  logic [DW-1:0]        cur_hi,
    input  logic [DW-1:0]        cur_lo,
    output logic [DW-1:0]        nxt_hi,
    output logic [DW-1:0]        nxt_lo
);

    localparam logic [AW-1:0] LMAX = {{(AW-LSAT_W+1){1'b0}}, {(LSAT_W-1){1'b1}}};
    localparam logic [AW-1:0] LMIN = ~LMAX;
    localparam logic [DW-1:0] WMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] WMIN = ~WMAX;
    localparam logic [DW-1:0] WFLAG = {{(DW-1){1'b0}}, 1'b1};

    logic [AW-1:0] acc, sum, wsum, res;
    logic          ovf64, lfits, wfits;

    // full-width sum and overflow/range tests
    always_comb begin
        acc   = {cur_hi, cur_lo};
        sum   = acc + prod;
        ovf64 = ((sum ^ acc) & (sum ^ prod)) >> (AW-1) != '0;
        lfits = (&sum[AW-1:LSAT_W-1]) || !(|sum[AW-1:LSAT_W-1]);
        wsum  = {{DW{cur_lo[DW-1]}}, cur_lo} + prod;
        wfits = (&wsum[AW-1:DW-1]) || !(|wsum[AW-1:DW-1]);
    end

    // select the result for the mode and saturate setting
    always_comb begin
        res = sum;
        if (sat && mode == MODE_LONG) begin
            if (ovf64)       res = acc[AW-1] ? LMIN : LMAX;
            else if (!lfits) res = sum[AW-1] ? LMIN : LMAX;
        end else if (sat) begin
            if (wfits)       res = {cur_hi, wsum[DW-1:0]};
            else             res = {WFLAG, wsum[AW-1] ? WMIN : WMAX};
        end
        nxt_hi = res[AW-1:DW];
        nxt_lo = res[DW-1:0];
    end

endmodule

// File: rtl/mac_sat_unit.sv
// Top: two-stage saturating multiply-accumulate with a split accumulator.
// Clear outranks loads, and loads outrank an accumulate in the same cycle.
// Assumes: synchronous active-low reset; one operation per valid strobe.
module mac_sat_unit
    import mac_sat_pkg::*;
#(
    parameter int DW     = 32,
    parameter int LSAT_W = 48,
    localparam int AW    = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic          op_long,
    input  logic          op_sat,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic          acc_clr,
    input  logic          ld_hi,
    input  logic          ld_lo,
    input  logic [DW-1:0] ld_data,
    output logic          done,
    output logic [DW-1:0] acc_hi,
    output logic [DW-1:0] acc_lo
);

    mac_ctl_t             s1_ctl;
    logic signed [AW-1:0] s1_prod;
    logic [DW-1:0]        nxt_hi, nxt_lo;
    logic                 any_ld;

    mac_sat_mult #(.DW(DW)) u_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (op_valid),
        .in_long (op_long),
        .in_sat  (op_sat),
        .in_a    (op_a),
        .in_b    (op_b),
        .s1_ctl  (s1_ctl),
        .s1_prod (s1_prod)
    );

    mac_sat_next #(.DW(DW), .LSAT_W(LSAT_W)) u_next (
        .mode   (s1_ctl.mode),
        .sat    (s1_ctl.sat),
        .prod   (s1_prod),
        .cur_hi (acc_hi),
        .cur_lo (acc_lo),
        .nxt_hi (nxt_hi),
        .nxt_lo (nxt_lo)
    );

    // any test write this cycle
    always_comb any_ld = ld_hi || ld_lo;

    // accumulator halves: clear, then loads, then accumulate
    always_ff @(posedge clk) begin
        if (!rst_n || acc_clr) begin
            acc_hi <= '0;
            acc_lo <= '0;
        end else if (any_ld) begin
            if (ld_hi) acc_hi <= ld_data;
            if (ld_lo) acc_lo <= ld_data;
        end else if (s1_ctl.vld) begin
            acc_hi <= nxt_hi;
            acc_lo <= nxt_lo;
        end
    end

    // completion strobe, one cycle per operation
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= s1_ctl.vld;
    end

    // R2: a strobe is followed two edges later by done
    assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> ##1 done);

    // R6: a saturating long accumulate leaves a value inside the 48-bit range
    assert_long_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_ctl.vld && s1_ctl.mode == MODE_LONG && s1_ctl.sat && !acc_clr && !any_ld)
        |=> ((&acc_hi[DW-1:LSAT_W-DW-1]) || !(|acc_hi[DW-1:LSAT_W-DW-1])));

    // R8/R9: a saturating word accumulate leaves the high half unchanged or sets it to 1
    assert_word_hi_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_ctl.vld && s1_ctl.mode == MODE_WORD && s1_ctl.sat && !acc_clr && !any_ld)
        |=> (acc_hi == $past(acc_hi) || acc_hi == DW'(1)));

    // R10: clear empties both halves
    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> (acc_hi == '0 && acc_lo == '0));

    // R11: a low-half load takes the data bus value
    assert_load_lo_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_lo && !acc_clr) |=> acc_lo == $past(ld_data));

endmodule

// File: tb/sim_mac_sat_unit.sv
`timescale 1ns/1ps
module sim_mac_sat_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_long = 1'b0, op_sat = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        acc_clr = 1'b0, ld_hi = 1'b0, ld_lo = 1'b0;
    logic [31:0] ld_data = '0;
    logic        done;
    logic [31:0] acc_hi, acc_lo;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mac_sat_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_long(op_long),
        .op_sat(op_sat), .op_a(op_a), .op_b(op_b), .acc_clr(acc_clr),
        .ld_hi(ld_hi), .ld_lo(ld_lo), .ld_data(ld_data), .done(done),
        .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    function automatic logic [63:0] ref_next(logic [63:0] acc, logic [31:0] a,
                                             logic [31:0] b, bit lng, bit sat);
        longint p, s, t, sacc;
        longint lim_hi = 64'sh0000_7FFF_FFFF_FFFF;
        longint lim_lo = 64'shFFFF_8000_0000_0000;
        if (lng) p = longint'($signed(a)) * longint'($signed(b));
        else     p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        sacc = longint'(acc);
        s = sacc + p;
        if (!sat) return 64'(s);
        if (lng) begin
            if ((sacc < 0) == (p < 0) && (s < 0) != (sacc < 0))
                return sacc < 0 ? 64'(lim_lo) : 64'(lim_hi);
            if (s > lim_hi) return 64'(lim_hi);
            if (s < lim_lo) return 64'(lim_lo);
            return 64'(s);
        end
        t = longint'($signed(acc[31:0])) + p;
        if (t > 64'sd2147483647)  return {32'd1, 32'h7FFF_FFFF};
        if (t < -64'sd2147483648) return {32'd1, 32'h8000_0000};
        return {acc[63:32], 32'(t)};
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic load_acc(logic [63:0] v);
        @(negedge clk); ld_hi = 1; ld_data = v[63:32];
        @(negedge clk); ld_hi = 0; ld_lo = 1; ld_data = v[31:0];
        @(negedge clk); ld_lo = 0;
    endtask

    // one operation; checks done timing and the result
    task automatic run_op(string req, logic [31:0] a, logic [31:0] b, bit lng, bit sat,
                          logic [63:0] exp);
        @(negedge clk);
        op_valid = 1; op_a = a; op_b = b; op_long = lng; op_sat = sat;
        @(negedge clk);
        op_valid = 0;
        check("R2 done low after first edge", {63'd0, done}, 64'd0);
        @(negedge clk);
        check("R2 done high after second edge", {63'd0, done}, 64'd1);
        check(req, {acc_hi, acc_lo}, exp);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 reset acc", {acc_hi, acc_lo}, 64'd0);
        check("R1 reset done", {63'd0, done}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", {acc_hi, acc_lo}, 64'd0);

        // R11 loads
        load_acc(64'h1234_5678_9ABC_DEF0);
        check("R11 load both halves", {acc_hi, acc_lo}, 64'h1234_5678_9ABC_DEF0);

        // R3 long wrap: 0x7FFF.. plus 1*1 wraps to most negative
        load_acc(64'h7FFF_FFFF_FFFF_FFFF);
        run_op("R3 long wrap", 32'd1, 32'd1, 1, 0, 64'h8000_0000_0000_0000);

        // R5 overflow, positive and negative
        load_acc(64'h7FFF_FFFF_FFFF_FFFF);
        run_op("R5 long ovf positive", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 1, 64'h0000_7FFF_FFFF_FFFF);
        load_acc(64'h8000_0000_0000_0000);
        run_op("R5 long ovf negative", 32'h7FFF_FFFF, 32'h8000_0000, 1, 1, 64'hFFFF_8000_0000_0000);

        // R6 clamp at 48 bits without 64-bit overflow
        load_acc(64'd0);
        run_op("R6 long clamp high", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 1, 64'h0000_7FFF_FFFF_FFFF);
        load_acc(64'd0);
        run_op("R6 long clamp low", 32'h7FFF_FFFF, 32'h8000_0001, 1, 1, 64'hFFFF_8000_0000_0000);
        load_acc(64'd10);
        run_op("R7 long in range split", 32'hFFFF_FFFF, 32'h0001_0000, 1, 1, 64'hFFFF_FFFF_FFFF_000A);

        // R8/R9 word saturation
        load_acc({32'hABCD_0000, 32'h7FFF_FFF0});
        run_op("R8 word clamp high", 32'h5555_7FFF, 32'hAAAA_7FFF, 0, 1, {32'd1, 32'h7FFF_FFFF});
        load_acc({32'hABCD_0000, 32'h8000_0000});
        run_op("R8 word clamp low", 32'h0000_8000, 32'h0000_7FFF, 0, 1, {32'd1, 32'h8000_0000});
        load_acc({32'h0000_ABCD, 32'd5});
        run_op("R9 word keeps high", 32'hFFFF_0003, 32'h1234_FFFE, 0, 1, {32'h0000_ABCD, 32'hFFFF_FFFF});

        // R4 word wrap carries into high half, upper operand bits ignored
        load_acc({32'd0, 32'hFFFF_FFFF});
        run_op("R4 word wrap carry", 32'hDEAD_0001, 32'hBEEF_0001, 0, 0, 64'h0000_0001_0000_0000);

        // R2 back to back
        load_acc(64'd100);
        @(negedge clk); op_valid = 1; op_long = 1; op_sat = 0; op_a = 3; op_b = 4;
        @(negedge clk); op_a = 32'hFFFF_FFFF; op_b = 5;
        @(negedge clk); op_valid = 0;
        check("R2 first of pair", {acc_hi, acc_lo}, 64'd112);
        @(negedge clk);
        check("R2 second of pair", {acc_hi, acc_lo}, 64'd107);

        // R10 clear beats load and accumulate
        @(negedge clk); op_valid = 1; op_a = 7; op_b = 7;
        @(negedge clk); op_valid = 0; acc_clr = 1; ld_hi = 1; ld_data = 32'hFFFF_FFFF;
        @(negedge clk); acc_clr = 0; ld_hi = 0;
        check("R10 clear priority", {acc_hi, acc_lo}, 64'd0);

        // R11 load suppresses accumulate
        @(negedge clk); op_valid = 1; op_a = 9; op_b = 9;
        @(negedge clk); op_valid = 0; ld_lo = 1; ld_data = 32'h0000_0042;
        @(negedge clk); ld_lo = 0;
        check("R11 load over accumulate", {acc_hi, acc_lo}, 64'h42);

        // random mix against the reference
        for (int i = 0; i < 400; i++) begin
            logic [63:0] st;
            logic [31:0] a, b;
            bit lng, sat;
            case ($urandom % 4)
                0: st = {$urandom, $urandom};
                1: st = {{17{1'($urandom)}}, 15'($urandom), $urandom};
                2: st = {$urandom, 1'($urandom), {30{1'($urandom)}}, 1'($urandom)};
                default: st = {$urandom % 2 ? 32'h7FFF_FFFF : 32'h8000_0000, $urandom};
            endcase
            a = $urandom; b = $urandom;
            lng = 1'($urandom); sat = 1'($urandom);
            load_acc(st);
            run_op(lng ? (sat ? "R5/R6 random long sat" : "R3 random long wrap")
                       : (sat ? "R8/R9 random word sat" : "R4 random word wrap"),
                   a, b, lng, sat, ref_next(st, a, b, lng, sat));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule